// File: doc/BRIEF.md
# Disk Transfer FIFO with DMA Service Threshold

This block buffers the bytes of a disk data transfer between the host DMA channel and the serial disk engine. In the read direction the disk side produces bytes and the host drains them. In the write direction the host supplies bytes and the disk side consumes them. The host side has no address decode. A single acknowledge strobe (`host_ack`) both selects the buffer and moves one byte. The block raises `dma_req` when the buffer needs service. The point at which it raises the request depends on a programmable threshold and on whether the 16-byte buffer is enabled or the block is running as a one-byte holding register.

A pulse on `exec_start` marks entry into the execution phase of a command. On that pulse the block:
- discards everything it holds,
- clears both error flags,
- restarts the sector byte count,
- latches the direction, the enable and the threshold for the coming transfer.

A disk byte pushed into a full buffer is an overrun. The block stops accepting disk data and lets the host drain what remains. A disk byte pulled from an empty buffer in the write direction is an underrun. The block then feeds zero bytes to the disk up to the end of the current sector and pulses `crc_go` to request the trailing CRC.

The controller has five states:
- IDLE: after reset.
- XFER: transfer running.
- PAD: zero fill after an underrun.
- DRAIN: host empties the buffer after an overrun.
- DONE: transfer ended.

The transitions are:
- Any state goes to XFER on `exec_start`.
- XFER goes to DRAIN on overrun.
- XFER goes to PAD on an underrun that is not the last byte of a sector.
- XFER goes to DONE on an underrun that is the last byte of a sector.
- PAD goes to DONE after the last byte of the sector.
- DRAIN goes to DONE once the buffer is empty.

Top module: `disk_fifo_dma`

## Requirements
- R1: After reset `dma_req`, `err_overrun`, `err_underrun` and `crc_go` are 0, and the block is in byte mode with capacity 1 until an `exec_start` latches a set `cfg_fifo_en`.
- R2: `exec_start` discards all buffered bytes, clears both error flags and restarts the sector count. Only bytes written after it are delivered.
- R3: Bytes leave in the order they entered. `host_rdata` shows the oldest byte in the read direction, and `disk_out` shows it in the write direction. With the buffer enabled it holds 16 bytes.
- R4: In byte mode (`cfg_fifo_en` latched as 0) the block holds at most one byte.
- R5: Enabled, read direction (`exec_dir`=0): `dma_req` is 1 exactly while the fill level is at least 16 − T. T is the latched `cfg_thresh`, and a value of 0 is treated as 1.
- R6: Enabled, write direction (`exec_dir`=1): `dma_req` is 1 exactly while the free space is at least T.
- R7: In byte mode the threshold is ignored. `dma_req` is 1 while a byte is held (read direction) or while the holder is empty (write direction).
- R8: A disk byte offered (`disk_stb`) while the buffer is full and the host does not take a byte in the same cycle sets `err_overrun` and is dropped. The block then ignores further disk bytes and keeps `dma_req` high while bytes remain for the host.
- R9: A disk pull from an empty buffer in the write direction sets `err_underrun`. That byte and every later byte up to the end of the sector (`SECTOR_BYTES`) are 0x00 on `disk_out`. `crc_go` is a one-cycle pulse in the cycle after the last byte of the sector.
- R10: The error flags stay set until the next `exec_start`.
- R11: Direction, enable and threshold are sampled only on `exec_start`. Changing them during a transfer has no effect.
- R12: In DONE, and in the zero-fill phase, `dma_req` is 0 and host strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fifo_en | input | 1 | 1 = 16-byte buffer, 0 = one-byte holder (sampled on exec_start) |
| cfg_thresh | input | 4 | Service threshold T (sampled on exec_start) |
| exec_start | input | 1 | Execution-phase entry pulse |
| exec_dir | input | 1 | 0 = disk read, 1 = disk write (sampled on exec_start) |
| host_ack | input | 1 | DMA acknowledge; moves one host byte |
| host_wdata | input | 8 | Host byte written in write direction |
| host_rdata | output | 8 | Oldest buffered byte for the host |
| dma_req | output | 1 | DMA service request |
| disk_stb | input | 1 | Disk side moves one byte |
| disk_in | input | 8 | Disk byte in read direction |
| disk_out | output | 8 | Byte to the disk in write direction (0x00 during fill) |
| err_overrun | output | 1 | Sticky overrun flag |
| err_underrun | output | 1 | Sticky underrun flag |
| crc_go | output | 1 | One-cycle request to append CRC |

## Verification
The bench targets the exact fill level at which the request toggles on each side of each threshold, including threshold zero. A design that is off by one there would raise the request one byte early or late. It pushes a disk byte into a full buffer with and without a simultaneous host pop. A design that ignores the pop would flag a false overrun, and one that ignores fullness would overwrite data. It provokes an underrun partway into a sector. A wrong pad count shows up as `crc_go` arriving early, arriving late or lasting two cycles. It also changes configuration mid-transfer and reissues `exec_start` over stale data. A design that samples configuration continuously, or that fails to flush, would change its request level or deliver old bytes.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XFER,
        ST_PAD,
        ST_DRAIN,
        ST_DONE
    } xfer_state_t;
endpackage

// File: rtl/dfifo_store.sv
module dfifo_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            unique case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign head = mem[rptr];
endmodule

// File: rtl/dfifo_reqgen.sv
module dfifo_reqgen
    import dfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  xfer_state_t   state,
    input  logic          dir_wr,
    input  logic          buf_en,
    input  logic [TW-1:0] thr,
    input  logic [CW-1:0] count,
    output logic          dma_req
);
    logic [CW-1:0] thr_eff, fill_mark, free_cnt;

    always_comb begin
        thr_eff   = (thr == '0) ? CW'(1) : CW'(thr);
        fill_mark = CW'(DEPTH) - thr_eff;
        free_cnt  = CW'(DEPTH) - count;
        dma_req   = 1'b0;
        unique case (state)
            ST_XFER: begin
                if (!dir_wr)
                    dma_req = buf_en ? (count >= fill_mark) : (count != '0);
                else
                    dma_req = buf_en ? (free_cnt >= thr_eff) : (count == '0);
            end
            ST_DRAIN: dma_req = (count != '0);
            default:  dma_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/dfifo_ctrl.sv
module dfifo_ctrl
    import dfifo_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int SECTOR_BYTES = 512,
    localparam int TW          = $clog2(DEPTH),
    localparam int CW          = $clog2(DEPTH + 1),
    localparam int SW          = $clog2(SECTOR_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_start,
    input  logic          exec_dir,
    input  logic          cfg_fifo_en,
    input  logic [TW-1:0] cfg_thresh,
    input  logic          host_ack,
    input  logic          disk_stb,
    input  logic [CW-1:0] count,
    output xfer_state_t   state,
    output logic          dir_q,
    output logic          en_q,
    output logic [TW-1:0] thr_q,
    output logic          push,
    output logic          pop,
    output logic          flush,
    output logic          err_ovr,
    output logic          err_und,
    output logic          crc_go
);
    xfer_state_t   nstate;
    logic [SW-1:0] sect_q;
    logic          ovr_evt, und_evt, disk_byte, crc_set;
    logic          empty, full, last;
    logic [CW-1:0] cap;

    assign cap   = en_q ? CW'(DEPTH) : CW'(1);
    assign empty = (count == '0);
    assign full  = (count >= cap);
    assign last  = (sect_q == SW'(SECTOR_BYTES - 1));

    // next state and datapath strobes
    always_comb begin
        nstate    = state;
        push      = 1'b0;
        pop       = 1'b0;
        flush     = 1'b0;
        ovr_evt   = 1'b0;
        und_evt   = 1'b0;
        disk_byte = 1'b0;
        crc_set   = 1'b0;
        if (exec_start) begin
            flush  = 1'b1;
            nstate = ST_XFER;
        end else begin
            unique case (state)
                ST_XFER: begin
                    if (!dir_q) begin
                        pop = host_ack && !empty;
                        if (disk_stb) begin
                            if (!full || pop) push = 1'b1;
                            else begin
                                ovr_evt = 1'b1;
                                nstate  = ST_DRAIN;
                            end
                        end
                    end else begin
                        pop  = disk_stb && !empty;
                        push = host_ack && (!full || pop);
                        if (disk_stb) begin
                            disk_byte = 1'b1;
                            if (empty) begin
                                und_evt = 1'b1;
                                if (last) begin
                                    crc_set = 1'b1;
                                    nstate  = ST_DONE;
                                end else begin
                                    nstate = ST_PAD;
                                end
                            end
                        end
                    end
                end
                ST_PAD: begin
                    if (disk_stb) begin
                        disk_byte = 1'b1;
                        if (last) begin
                            crc_set = 1'b1;
                            nstate  = ST_DONE;
                        end
                    end
                end
                ST_DRAIN: begin
                    pop = host_ack && !empty;
                    if (empty) nstate = ST_DONE;
                end
                ST_IDLE, ST_DONE: nstate = state;
                default:          nstate = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // registered outputs and transfer context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= 1'b0;
            en_q    <= 1'b0;
            thr_q   <= '0;
            err_ovr <= 1'b0;
            err_und <= 1'b0;
            crc_go  <= 1'b0;
            sect_q  <= '0;
        end else begin
            crc_go <= crc_set;
            if (exec_start) begin
                dir_q   <= exec_dir;
                en_q    <= cfg_fifo_en;
                thr_q   <= cfg_thresh;
                err_ovr <= 1'b0;
                err_und <= 1'b0;
                sect_q  <= '0;
            end else begin
                if (ovr_evt) err_ovr <= 1'b1;
                if (und_evt) err_und <= 1'b1;
                if (disk_byte) sect_q <= last ? '0 : sect_q + SW'(1);
            end
        end
    end
endmodule

// File: rtl/disk_fifo_dma.sv
module disk_fifo_dma
    import dfifo_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int SECTOR_BYTES = 512,
    localparam int TW          = $clog2(DEPTH),
    localparam int CW          = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_fifo_en,
    input  logic [TW-1:0] cfg_thresh,
    input  logic          exec_start,
    input  logic          exec_dir,
    input  logic          host_ack,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    output logic          dma_req,
    input  logic          disk_stb,
    input  logic [7:0]    disk_in,
    output logic [7:0]    disk_out,
    output logic          err_overrun,
    output logic          err_underrun,
    output logic          crc_go
);
    xfer_state_t   state;
    logic          dir_q, en_q, push, pop, flush;
    logic [TW-1:0] thr_q;
    logic [CW-1:0] count;
    logic [7:0]    head, wbyte;

    dfifo_ctrl #(.DEPTH(DEPTH), .SECTOR_BYTES(SECTOR_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .exec_start(exec_start), .exec_dir(exec_dir),
        .cfg_fifo_en(cfg_fifo_en), .cfg_thresh(cfg_thresh), .host_ack(host_ack),
        .disk_stb(disk_stb), .count(count), .state(state), .dir_q(dir_q),
        .en_q(en_q), .thr_q(thr_q), .push(push), .pop(pop), .flush(flush),
        .err_ovr(err_overrun), .err_und(err_underrun), .crc_go(crc_go)
    );

    assign wbyte = dir_q ? host_wdata : disk_in;

    dfifo_store #(.DEPTH(DEPTH), .W(8)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
        .wdata(wbyte), .head(head), .count(count)
    );

    dfifo_reqgen #(.DEPTH(DEPTH)) u_req (
        .state(state), .dir_wr(dir_q), .buf_en(en_q), .thr(thr_q),
        .count(count), .dma_req(dma_req)
    );

    assign host_rdata = head;
    assign disk_out   = (state == ST_XFER && dir_q && count != '0) ? head : 8'h00;
endmodule

// File: rtl/disk_fifo_dma_chk.sv
module disk_fifo_dma_chk
    import dfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          exec_start,
    input logic          disk_stb,
    input logic          dma_req,
    input logic          err_overrun,
    input logic          err_underrun,
    input logic          crc_go,
    input xfer_state_t   state,
    input logic          en_q,
    input logic [CW-1:0] count
);
    // R9
    crc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_go |=> !crc_go);
    // R10
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_overrun && !exec_start) |=> err_overrun);
    // R10
    und_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_underrun && !exec_start) |=> err_underrun);
    // R2
    exec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |=> (!err_overrun && !err_underrun && count == '0));
    // R12
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE || state == ST_PAD) |-> !dma_req);
    // R4
    byte_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (count <= CW'(1)));
    // R8
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> $past(disk_stb));
endmodule

bind disk_fifo_dma disk_fifo_dma_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .exec_start(exec_start), .disk_stb(disk_stb),
    .dma_req(dma_req), .err_overrun(err_overrun), .err_underrun(err_underrun),
    .crc_go(crc_go), .state(state), .en_q(en_q), .count(count)
);

// File: tb/disk_fifo_dma_test.sv
`timescale 1ns/1ps
module disk_fifo_dma_test;
    localparam int SECT = 8;

    logic       clk = 0, rst_n = 0;
    logic       cfg_fifo_en = 1, exec_start = 0, exec_dir = 0;
    logic [3:0] cfg_thresh = 0;
    logic       host_ack = 0, disk_stb = 0;
    logic [7:0] host_wdata = 0, disk_in = 0;
    logic [7:0] host_rdata, disk_out;
    logic       dma_req, err_overrun, err_underrun, crc_go;

    int vectors = 0, miscompares = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    disk_fifo_dma #(.DEPTH(16), .SECTOR_BYTES(SECT)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en), .cfg_thresh(cfg_thresh),
        .exec_start(exec_start), .exec_dir(exec_dir), .host_ack(host_ack),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .dma_req(dma_req),
        .disk_stb(disk_stb), .disk_in(disk_in), .disk_out(disk_out),
        .err_overrun(err_overrun), .err_underrun(err_underrun), .crc_go(crc_go)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 idle, 1 xfer, 2 pad, 3 drain, 4 done
    logic [7:0] mq[$];
    int  ms = 0, mthr = 0, msect = 0, sz = 0, cap = 1;
    bit  mdir = 0, men = 0, movr = 0, mund = 0, mcrc = 0, popd = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); ms = 0; mdir = 0; men = 0; mthr = 0;
            movr = 0; mund = 0; mcrc = 0; msect = 0;
        end else begin
            mcrc = 0;
            sz   = mq.size();
            cap  = men ? 16 : 1;
            if (exec_start) begin
                mq.delete(); ms = 1; mdir = exec_dir; men = cfg_fifo_en;
                mthr = cfg_thresh; movr = 0; mund = 0; msect = 0;
            end else if (ms == 1 && !mdir) begin
                popd = host_ack && sz > 0;
                if (popd) void'(mq.pop_front());
                if (disk_stb) begin
                    if (sz < cap || popd) mq.push_back(disk_in);
                    else begin movr = 1; ms = 3; end
                end
            end else if (ms == 1) begin
                popd = disk_stb && sz > 0;
                if (popd) void'(mq.pop_front());
                if (host_ack && (sz < cap || popd)) mq.push_back(host_wdata);
                if (disk_stb) begin
                    if (sz == 0) begin
                        mund = 1;
                        if (msect == SECT - 1) begin mcrc = 1; ms = 4; end
                        else ms = 2;
                    end
                    msect = (msect + 1) % SECT;
                end
            end else if (ms == 2) begin
                if (disk_stb) begin
                    if (msect == SECT - 1) begin mcrc = 1; ms = 4; end
                    msect = (msect + 1) % SECT;
                end
            end else if (ms == 3) begin
                if (host_ack && sz > 0) void'(mq.pop_front());
                if (sz == 0) ms = 4;
            end
        end
    end

    function automatic bit exp_req();
        int n = mq.size();
        int te = (mthr == 0) ? 1 : mthr;
        if (ms == 1 && !mdir) return men ? (n >= 16 - te) : (n > 0);
        if (ms == 1 && mdir)  return men ? (16 - n >= te) : (n == 0);
        if (ms == 3)          return n > 0;
        return 0;
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            check(mdir ? "R6 req" : "R5 req", dma_req, exp_req());
            check("R8 ovr", err_overrun, movr);
            check("R9 und", err_underrun, mund);
            check("R9 crc", crc_go, mcrc);
            check("R3 disk_out", disk_out,
                  (ms == 1 && mdir && mq.size() > 0) ? mq[0] : 0);
            if ((ms == 1 || ms == 3) && !mdir && mq.size() > 0)
                check("R3 host_rdata", host_rdata, mq[0]);
        end
    end

    task automatic step(input bit ha, input logic [7:0] hd, input bit ds, input logic [7:0] dd);
        host_ack = ha; host_wdata = hd; disk_stb = ds; disk_in = dd;
        @(posedge clk); #2;
        host_ack = 0; disk_stb = 0;
    endtask

    task automatic exec(input bit dir, input bit en, input logic [3:0] thr);
        exec_dir = dir; cfg_fifo_en = en; cfg_thresh = thr; exec_start = 1;
        @(posedge clk); #2;
        exec_start = 0;
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        vectors++; miscompares++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R1 reset state
        check("R1 req", dma_req, 0);
        check("R1 ovr", err_overrun, 0);
        check("R1 crc", crc_go, 0);

        // byte mode, read direction
        exec(0, 0, 5);
        step(0, 0, 1, 8'h11);
        check("R7 byte read req", dma_req, 1);
        step(0, 0, 1, 8'h22);
        check("R4 byte capacity overrun", err_overrun, 1);
        check("R8 drain req", dma_req, 1);
        step(0, 0, 1, 8'h33);
        check("R8 dropped, head kept", host_rdata, 8'h11);
        step(1, 0, 0, 0);
        step(0, 0, 0, 0);
        check("R12 done req", dma_req, 0);
        step(1, 0, 1, 8'h44);
        check("R10 ovr sticky", err_overrun, 1);

        // enabled read, threshold 4
        exec(0, 1, 4);
        check("R10 cleared by exec", err_overrun, 0);
        for (int i = 0; i < 11; i++) step(0, 0, 1, 8'h40 + 8'(i));
        check("R5 below mark", dma_req, 0);
        step(0, 0, 1, 8'h4B);
        check("R5 at mark", dma_req, 1);
        cfg_thresh = 1; cfg_fifo_en = 0;
        step(0, 0, 0, 0);
        check("R11 config ignored", dma_req, 1);
        for (int i = 0; i < 12; i++) begin
            check("R3 order", host_rdata, 8'h40 + i);
            step(1, 0, 0, 0);
        end
        check("R5 empty", dma_req, 0);
        for (int i = 0; i < 16; i++) step(0, 0, 1, 8'h80 + 8'(i));
        check("R3 depth 16", err_overrun, 0);
        step(1, 0, 1, 8'h90);
        check("R8 pop same cycle", err_overrun, 0);
        step(0, 0, 1, 8'h91);
        check("R8 overrun", err_overrun, 1);

        // threshold 0 acts as 1
        exec(0, 1, 0);
        for (int i = 0; i < 14; i++) step(0, 0, 1, 8'(i));
        check("R5 thr0 at 14", dma_req, 0);
        step(0, 0, 1, 8'h0E);
        check("R5 thr0 at 15", dma_req, 1);
        exec(0, 1, 0);
        check("R2 flushed req", dma_req, 0);
        step(0, 0, 1, 8'hA5);
        check("R2 fresh head", host_rdata, 8'hA5);

        // enabled write, threshold 8
        exec(1, 1, 8);
        check("R6 empty req", dma_req, 1);
        for (int i = 0; i < 8; i++) step(1, 8'h60 + 8'(i), 0, 0);
        check("R6 free 8", dma_req, 1);
        step(1, 8'h68, 0, 0);
        check("R6 free 7", dma_req, 0);
        for (int i = 0; i < 9; i++) begin
            check("R3 disk order", disk_out, 8'h60 + i);
            step(0, 0, 1, 0);
        end
        step(0, 0, 1, 0);
        check("R9 underrun", err_underrun, 1);
        check("R9 pad zero", disk_out, 0);
        step(1, 8'hEE, 0, 0);
        check("R12 host ignored in pad", dma_req, 0);
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0);
        check("R9 no early crc", crc_go, 0);
        step(0, 0, 1, 0);
        check("R9 crc at sector end", crc_go, 1);
        step(0, 0, 0, 0);
        check("R9 crc one cycle", crc_go, 0);

        // byte mode write
        exec(1, 0, 9);
        check("R7 byte write empty", dma_req, 1);
        step(1, 8'h77, 0, 0);
        check("R7 byte write held", dma_req, 0);
        check("R3 byte out", disk_out, 8'h77);
        step(0, 0, 1, 0);
        step(0, 0, 0, 0);
        finish_run();
    end
endmodule